// File: doc/BRIEF.md
# Clock-plus-NRZ Coarse Time Distribution Link

This block carries coarse time of day from one board to others over two wires. The master side divides the system clock into a square-wave sync clock. Each rising edge that opens a new second marks the exact second boundary. The master shifts a framed copy of its coarse time word onto a data line that changes only on rising edges. The slave side samples that data line on falling edges. It rebuilds the frame and checks it. At the rising edge that opens the next second, it hands the time word to a local time-stamp counter together with a load strobe and a once-per-second sync pulse.

A frame carries a 16-bit start marker (0xF35A), then the nine-digit BCD time word (days, hours, minutes, seconds, 36 bits), then an 8-bit check byte. All fields go out MSB first. The frame sits in the last 60 bit slots of each second, and the line is low in all other slots. The time word that is sent belongs to the boundary that closes the frame. The master samples it one slot before the marker starts. A board that only buffers the signals for others uses the same slave logic. Both halves sit in one top so that one instance can serve as master, slave or both.

Master states: TX_IDLE (line low) moves to TX_SEND on the rising edge that enters the slot just before the frame, and the frame is loaded on that edge. TX_SEND returns to TX_IDLE on the rising edge after the 60th bit. Slave states: RX_HUNT moves to RX_TIME when the last 16 sampled bits equal the marker. RX_TIME moves to RX_SUM after 36 bits. RX_SUM moves to RX_ARM if the frame is good and back to RX_HUNT if it is not. RX_ARM moves to RX_HUNT on the next rising edge, which also applies the time.

Top module: `tsync_link`

## Requirements
- R1: `tx_clk_o` is a square wave whose high and low phases each last HALF_DIV clock cycles. Each second holds BITS_PER_SEC rising edges. `tx_second_o` pulses for one cycle together with the rising edge that opens each second.
- R2: Slots are numbered from 0 at the second's rising edge. Slots 0 to BITS_PER_SEC-61 are low. The last 60 slots carry marker 0xF35A, the 36-bit time word and the check byte, all MSB first. The check byte is the bitwise inverse of the 8-bit sum of the nine 4-bit digits. `tx_dat_o` changes only together with a rising edge of `tx_clk_o`.
- R3: The time word sent in a second is `tx_time_i` as sampled at the rising edge that opens slot BITS_PER_SEC-61.
- R4: The slave synchronises both line inputs through two flops. It samples data on falling edges of `rx_clk_i` and starts a frame only after the 16-bit marker has been seen.
- R5: After a good frame, `rx_time_o` takes the received word and `rx_load_o` pulses for one cycle at the first following rising edge. When master and slave are looped back, this happens within 4 cycles of `tx_second_o`.
- R6: A frame whose check byte does not match is discarded. No load occurs and `rx_time_o` keeps its value.
- R7: A frame that holds any digit above 9 is discarded, even when its check byte is right.
- R8: `rx_sync_o` pulses on every load and then every BITS_PER_SEC rising edges, also in seconds without a good frame.
- R9: `rx_lost_o` rises when 2·BITS_PER_SEC rising edges pass without a load, and a load clears it.
- R10: In reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_time_i | input | 36 | Master coarse time (BCD) for the coming boundary |
| tx_clk_o | output | 1 | Sync clock driven to the line |
| tx_dat_o | output | 1 | NRZ data driven to the line |
| tx_second_o | output | 1 | Master second-boundary pulse |
| rx_clk_i | input | 1 | Sync clock received from the line |
| rx_dat_i | input | 1 | NRZ data received from the line |
| rx_time_o | output | 36 | Last accepted coarse time |
| rx_load_o | output | 1 | Strobe: load `rx_time_o` into the local counter |
| rx_sync_o | output | 1 | Once-per-second alignment pulse |
| rx_lost_o | output | 1 | No good frame for two seconds |

## Verification
The hardest state to reach is one where the slave free-runs on its own edge count while frames keep failing, and the loss flag must rise exactly two seconds after the last good load. The bench loops the master into the slave through a line model that it can alter. It flips one data bit in the middle of a chosen frame to spoil the check byte. It sends a word with a non-decimal digit and a correct check byte. It then holds the data line low for three whole seconds. After every boundary, a scoreboard compares load, time, sync and loss against values derived from that history.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

    localparam int MARK_W  = 16;
    localparam int TIME_W  = 36;
    localparam int SUM_W   = 8;
    localparam int DIGITS  = TIME_W / 4;
    localparam int FRAME_W = MARK_W + TIME_W + SUM_W;

    localparam logic [MARK_W-1:0] MARKER = 16'hF35A;

    typedef logic [TIME_W-1:0] coarse_t;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_TIME,
        RX_SUM,
        RX_ARM
    } rx_state_e;

    // Inverted 8-bit sum of all BCD digits
    function automatic logic [SUM_W-1:0] frame_check(coarse_t t);
        logic [SUM_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < DIGITS; i++) begin
            acc = acc + {4'b0000, t[4*i +: 4]};
        end
        return ~acc;
    endfunction

    function automatic logic digits_ok(coarse_t t);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (t[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/tsync_master.sv
module tsync_master
    import tsync_pkg::*;
#(
    parameter int HALF_DIV     = 5,
    parameter int BITS_PER_SEC = 10_000_000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  coarse_t time_i,
    output logic    line_clk_o,
    output logic    line_dat_o,
    output logic    boundary_o
);

    localparam int HC_W       = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int SLOT_W     = $clog2(BITS_PER_SEC);
    localparam int FIRST_SLOT = BITS_PER_SEC - FRAME_W;
    localparam int CNT_W      = $clog2(FRAME_W + 1);

    localparam logic [HC_W-1:0]   HC_LAST   = HC_W'(HALF_DIV - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(BITS_PER_SEC - 1);
    localparam logic [SLOT_W-1:0] SLOT_LOAD = SLOT_W'(FIRST_SLOT - 1);
    localparam logic [CNT_W-1:0]  CNT_DONE  = CNT_W'(FRAME_W);

    logic [HC_W-1:0]    hc_q;
    logic               clk_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [SLOT_W-1:0]  slot_next;
    logic               bnd_q;
    logic               half_end;
    logic               rise_now;
    tx_state_e          state_q, state_d;
    logic [FRAME_W-1:0] frame_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               dat_q;

    assign half_end  = (hc_q == HC_LAST);
    assign rise_now  = half_end && !clk_q;
    assign slot_next = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;

    // Sync clock divider and slot position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc_q   <= '0;
            clk_q  <= 1'b0;
            slot_q <= SLOT_LAST;
            bnd_q  <= 1'b0;
        end else begin
            hc_q  <= half_end ? '0 : hc_q + 1'b1;
            bnd_q <= rise_now && (slot_next == '0);
            if (half_end) clk_q <= !clk_q;
            if (rise_now) slot_q <= slot_next;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (rise_now && slot_next == SLOT_LOAD) state_d = TX_SEND;
            TX_SEND: if (rise_now && cnt_q == CNT_DONE)      state_d = TX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Outputs: frame load and serial shift on rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            cnt_q   <= '0;
            dat_q   <= 1'b0;
        end else if (rise_now) begin
            unique case (state_q)
                TX_IDLE: begin
                    dat_q <= 1'b0;
                    if (slot_next == SLOT_LOAD) begin
                        frame_q <= {MARKER, time_i, frame_check(time_i)};
                        cnt_q   <= '0;
                    end
                end
                TX_SEND: begin
                    if (cnt_q == CNT_DONE) begin
                        dat_q <= 1'b0;
                    end else begin
                        dat_q   <= frame_q[FRAME_W-1];
                        frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign line_clk_o = clk_q;
    assign line_dat_o = dat_q;
    assign boundary_o = bnd_q;

    // R2: data never moves except with a rising sync clock
    assert_dat_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_dat_o) |-> $rose(line_clk_o));

    // R2: line is idle low outside a frame
    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE) |-> !line_dat_o);

    // R1: second marker coincides with a rising sync clock
    assert_boundary_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_o |-> $rose(line_clk_o));

endmodule

// File: rtl/tsync_edge_sync.sv
module tsync_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_i,
    input  logic dat_i,
    output logic rise_o,
    output logic fall_o,
    output logic bit_o
);

    logic [2:0] c_q;
    logic [1:0] d_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
            d_q <= '0;
        end else begin
            c_q <= {c_q[1:0], clk_i};
            d_q <= {d_q[0], dat_i};
        end
    end

    assign rise_o = c_q[1] && !c_q[2];
    assign fall_o = !c_q[1] && c_q[2];
    assign bit_o  = d_q[1];

endmodule

// File: rtl/tsync_slave.sv
module tsync_slave
    import tsync_pkg::*;
#(
    parameter int BITS_PER_SEC = 10_000_000,
    parameter int LOST_SECONDS = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    line_clk_i,
    input  logic    line_dat_i,
    output coarse_t time_o,
    output logic    load_o,
    output logic    sync_o,
    output logic    lost_o
);

    localparam int SLOT_W    = $clog2(BITS_PER_SEC);
    localparam int TMR_LIMIT = LOST_SECONDS * BITS_PER_SEC;
    localparam int TMR_W     = $clog2(TMR_LIMIT + 1);
    localparam int CNT_W     = $clog2(TIME_W);

    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(BITS_PER_SEC - 1);
    localparam logic [TMR_W-1:0]  TMR_MAX   = TMR_W'(TMR_LIMIT);
    localparam logic [TMR_W-1:0]  TMR_PRE   = TMR_W'(TMR_LIMIT - 1);
    localparam logic [CNT_W-1:0]  TIME_LAST = CNT_W'(TIME_W - 1);
    localparam logic [CNT_W-1:0]  SUM_LAST  = CNT_W'(SUM_W - 1);

    logic              rise, fall, bit_s;
    rx_state_e         state_q, state_d;
    logic [MARK_W-1:0] hunt_q, hunt_next;
    coarse_t           word_q, time_q;
    logic [SUM_W-1:0]  sum_q, sum_next;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              frame_good;
    logic              load_now;
    logic              load_q, sync_q, lost_q;
    logic [SLOT_W-1:0] edge_cnt_q;
    logic [TMR_W-1:0]  tmr_q;

    tsync_edge_sync u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_i  (line_clk_i),
        .dat_i  (line_dat_i),
        .rise_o (rise),
        .fall_o (fall),
        .bit_o  (bit_s)
    );

    assign hunt_next  = {hunt_q[MARK_W-2:0], bit_s};
    assign sum_next   = {sum_q[SUM_W-2:0], bit_s};
    assign frame_good = (sum_next == frame_check(word_q)) && digits_ok(word_q);
    assign load_now   = (state_q == RX_ARM) && rise;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HUNT: if (fall && hunt_next == MARKER)     state_d = RX_TIME;
            RX_TIME: if (fall && bit_cnt_q == TIME_LAST)  state_d = RX_SUM;
            RX_SUM:  if (fall && bit_cnt_q == SUM_LAST)
                         state_d = frame_good ? RX_ARM : RX_HUNT;
            RX_ARM:  if (rise)                            state_d = RX_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_HUNT;
        else        state_q <= state_d;
    end

    // Outputs: shifting on falling edges, apply on rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hunt_q    <= '0;
            word_q    <= '0;
            sum_q     <= '0;
            bit_cnt_q <= '0;
            time_q    <= '0;
            load_q    <= 1'b0;
        end else begin
            load_q <= 1'b0;
            unique case (state_q)
                RX_HUNT: if (fall) begin
                    hunt_q    <= (state_d == RX_TIME) ? '0 : hunt_next;
                    bit_cnt_q <= '0;
                end
                RX_TIME: if (fall) begin
                    word_q    <= {word_q[TIME_W-2:0], bit_s};
                    bit_cnt_q <= (bit_cnt_q == TIME_LAST) ? '0 : bit_cnt_q + 1'b1;
                end
                RX_SUM: if (fall) begin
                    sum_q     <= sum_next;
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
                RX_ARM: if (rise) begin
                    time_q <= word_q;
                    load_q <= 1'b1;
                end
            endcase
        end
    end

    // Free-running second counter and loss watchdog, both on rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt_q <= '0;
            sync_q     <= 1'b0;
            tmr_q      <= '0;
            lost_q     <= 1'b0;
        end else begin
            sync_q <= 1'b0;
            if (rise) begin
                if (load_now || edge_cnt_q == SLOT_LAST) begin
                    edge_cnt_q <= '0;
                    sync_q     <= 1'b1;
                end else begin
                    edge_cnt_q <= edge_cnt_q + 1'b1;
                end
                if (load_now) begin
                    tmr_q  <= '0;
                    lost_q <= 1'b0;
                end else if (tmr_q != TMR_MAX) begin
                    tmr_q <= tmr_q + 1'b1;
                    if (tmr_q == TMR_PRE) lost_q <= 1'b1;
                end
            end
        end
    end

    assign time_o = time_q;
    assign load_o = load_q;
    assign sync_o = sync_q;
    assign lost_o = lost_q;

    // R5: a load follows a detected rising edge of the line clock
    assert_load_after_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> $past(rise));

    // R6: received time is held between loads
    assert_time_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o |-> $stable(time_o));

    // R7: accepted word has only decimal digits
    assert_bcd_accepted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> digits_ok(time_o));

    // R8: every load realigns the second pulse
    assert_sync_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> sync_o);

    // R9: loss flag is low right after a load
    assert_lost_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !lost_o);

endmodule

// File: rtl/tsync_link.sv
module tsync_link
    import tsync_pkg::*;
#(
    parameter int HALF_DIV     = 5,
    parameter int BITS_PER_SEC = 10_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [35:0] tx_time_i,
    output logic        tx_clk_o,
    output logic        tx_dat_o,
    output logic        tx_second_o,
    input  logic        rx_clk_i,
    input  logic        rx_dat_i,
    output logic [35:0] rx_time_o,
    output logic        rx_load_o,
    output logic        rx_sync_o,
    output logic        rx_lost_o
);

    tsync_master #(
        .HALF_DIV     (HALF_DIV),
        .BITS_PER_SEC (BITS_PER_SEC)
    ) u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .time_i     (tx_time_i),
        .line_clk_o (tx_clk_o),
        .line_dat_o (tx_dat_o),
        .boundary_o (tx_second_o)
    );

    tsync_slave #(
        .BITS_PER_SEC (BITS_PER_SEC),
        .LOST_SECONDS (2)
    ) u_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_clk_i (rx_clk_i),
        .line_dat_i (rx_dat_i),
        .time_o     (rx_time_o),
        .load_o     (rx_load_o),
        .sync_o     (rx_sync_o),
        .lost_o     (rx_lost_o)
    );

endmodule

// File: tb/tsync_link_tb.sv
module tsync_link_tb;

    localparam int HALF  = 2;
    localparam int BPS   = 80;
    localparam int FS    = BPS - 60;
    localparam int SLOT  = 2 * HALF;
    localparam int NBND  = 13;

    typedef struct {
        bit          exp_load;
        bit          check_bits;
        logic [35:0] sent;
        logic [35:0] val;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] tx_time = '0;
    logic        flip = 1'b0;
    logic        kill = 1'b0;
    logic        tx_clk, tx_dat, tx_second;
    logic        rx_dat;
    logic [35:0] rx_time;
    logic        rx_load, rx_sync, rx_lost;

    always #4 clk = ~clk;

    assign rx_dat = kill ? 1'b0 : (tx_dat ^ flip);

    tsync_link #(.HALF_DIV(HALF), .BITS_PER_SEC(BPS)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_time_i   (tx_time),
        .tx_clk_o    (tx_clk),
        .tx_dat_o    (tx_dat),
        .tx_second_o (tx_second),
        .rx_clk_i    (tx_clk),
        .rx_dat_i    (rx_dat),
        .rx_time_o   (rx_time),
        .rx_load_o   (rx_load),
        .rx_sync_o   (rx_sync),
        .rx_lost_o   (rx_lost)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    item_t q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [35:0] tval(input int k);
        return {4'h1, 4'h2, 4'h3, 4'h2, 4'h3, 4'h5, 4'h9, 4'(k / 10), 4'(k % 10)};
    endfunction

    function automatic logic [7:0] csum(input logic [35:0] t);
        int s = 0;
        for (int i = 0; i < 9; i++) s += int'(t[4*i +: 4]);
        return ~8'(s);
    endfunction

    // Capture: observe line and slave outputs away from the clock edge
    longint      cyc = 0;
    logic        prev_clk = 1'b0;
    int          phase_len = 0;
    int          clk_bad = 0;
    int          rises = 0, rises_prev = 0;
    int          slot = 0;
    logic [BPS-1:0] line_bits = '0, prev_bits = '0;
    longint      bnd_cyc = 0, load_cyc = 0, sync_cyc = 0;
    int          bnd_cnt = 0, load_cnt = 0, sync_cnt = 0;
    logic [35:0] load_val = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (tx_clk == prev_clk) phase_len++;
            else begin
                if (bnd_cnt > 0 && phase_len != HALF) clk_bad++;
                phase_len = 1;
            end
            if (tx_clk && !prev_clk) begin
                if (tx_second) begin
                    prev_bits  = line_bits;
                    line_bits  = '0;
                    slot       = 0;
                    rises_prev = rises;
                    rises      = 1;
                    bnd_cyc    = cyc;
                    bnd_cnt++;
                end else begin
                    slot++;
                    rises++;
                end
            end
            if (!tx_clk && prev_clk && slot < BPS) line_bits[slot] = tx_dat;
            if (rx_load) begin
                load_cnt++;
                load_val = rx_time;
                load_cyc = cyc;
            end
            if (rx_sync) begin
                sync_cnt++;
                sync_cyc = cyc;
            end
            prev_clk = tx_clk;
        end
    end

    // Driver
    initial begin
        item_t it;
        repeat (3) @(negedge clk);
        chk(tx_clk == 1'b0,    "R10", "tx_clk in reset",    64'(tx_clk), 64'd0);
        chk(tx_dat == 1'b0,    "R10", "tx_dat in reset",    64'(tx_dat), 64'd0);
        chk(tx_second == 1'b0, "R10", "tx_second in reset", 64'(tx_second), 64'd0);
        chk(rx_load == 1'b0,   "R10", "rx_load in reset",   64'(rx_load), 64'd0);
        chk(rx_sync == 1'b0,   "R10", "rx_sync in reset",   64'(rx_sync), 64'd0);
        chk(rx_lost == 1'b0,   "R10", "rx_lost in reset",   64'(rx_lost), 64'd0);
        chk(rx_time == '0,     "R10", "rx_time in reset",   64'(rx_time), 64'd0);
        it = '{exp_load: 1'b0, check_bits: 1'b0, sent: '0, val: '0, tag: "R5"};
        q.push_back(it);
        rst_n = 1'b1;
        for (int k = 0; k < NBND - 1; k++) begin
            wait (bnd_cnt > k);
            it = '{exp_load: 1'b1, check_bits: 1'b1, sent: tval(k), val: tval(k), tag: "R5"};
            if (k == 2) begin
                it.exp_load = 1'b0; it.tag = "R6";
            end else if (k == 3) begin
                it.sent = 36'h1C2000000; it.val = it.sent;
                it.exp_load = 1'b0; it.tag = "R7";
            end else if (k >= 5 && k <= 7) begin
                it.exp_load = 1'b0; it.tag = "R9";
                kill = 1'b1;
            end else begin
                kill = 1'b0;
            end
            tx_time = it.sent;
            q.push_back(it);
            if (k == 2) begin
                repeat (SLOT * (FS + 20)) @(negedge clk);
                flip = 1'b1;
                repeat (SLOT) @(negedge clk);
                flip = 1'b0;
            end
        end
    end

    // Monitor / scoreboard
    initial begin
        int seen = 0, pl = 0, ps = 0, pc = 0, last_load_b = 0;
        bit have_loaded = 1'b0;
        logic [35:0] last_good = '0;
        for (int b = 0; b < NBND; b++) begin
            item_t it;
            logic [59:0]    frame;
            logic [BPS-1:0] expb;
            int dl, ds;
            longint lat;
            bit exp_lost;
            wait (bnd_cnt > seen);
            seen = bnd_cnt;
            repeat (6) @(negedge clk);
            it = q.pop_front();
            if (b >= 1) begin
                chk(rises_prev == BPS, "R1", "rising edges per second", 64'(rises_prev), 64'(BPS));
                chk(clk_bad == pc, "R1", "sync clock phase length errors", 64'(clk_bad), 64'(pc));
                pc = clk_bad;
            end
            if (it.check_bits) begin
                frame = {16'hF35A, it.sent, csum(it.sent)};
                expb = '0;
                for (int j = 0; j < 60; j++) expb[FS + j] = frame[59 - j];
                chk(prev_bits == expb, "R2", "line slot pattern (R3 time latch)",
                    64'(prev_bits), 64'(expb));
            end
            dl = load_cnt - pl; pl = load_cnt;
            ds = sync_cnt - ps; ps = sync_cnt;
            chk(dl == int'(it.exp_load), it.tag, "loads at boundary", 64'(dl), 64'(it.exp_load));
            if (it.exp_load) begin
                chk(load_val == it.val, "R5", "received time (R4 sampling)", 64'(load_val), 64'(it.val));
                lat = load_cyc - bnd_cyc;
                chk(lat >= 1 && lat <= 4, "R5", "load latency", 64'(lat), 64'd3);
            end else if (have_loaded) begin
                chk(rx_time == last_good, it.tag, "time kept after discard", 64'(rx_time), 64'(last_good));
            end
            if (have_loaded) begin
                chk(ds == 1, "R8", "sync pulses per second", 64'(ds), 64'd1);
                lat = sync_cyc - bnd_cyc;
                chk(lat >= 1 && lat <= 4, "R8", "sync alignment", 64'(lat), 64'd3);
            end
            if (it.exp_load) begin
                have_loaded = 1'b1;
                last_load_b = b;
                last_good   = it.val;
            end
            exp_lost = have_loaded && !it.exp_load && (b - last_load_b >= 2);
            chk(rx_lost == exp_lost, "R9", "loss flag", 64'(rx_lost), 64'(exp_lost));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", bnd_cnt, NBND);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule